// File: doc/BRIEF.md
# Thermal Alert Pin Sense Controller

This block owns two shared, active-low, open-drain memory-overheat alert pins. The chip pulls a pin low when its internal hot request for that pin is active. Other agents on the board may pull the same pins low, so the block has to find out when that happens.

A prescaler divides the core clock into a 500 ns tick. A period counter runs in ticks. At the start of every sense period, and while sensing is enabled, the block releases its own drive on both pins for a short assertion window. Each pin level passes through a two-flop synchronizer. The level seen on the last tick of the window decides that pin's external-assert flag. A rise in the OR of the two flags can raise a one-cycle interrupt event.

Output generation and sensing are enabled separately. Turning the outputs off never stops the block from detecting external assertion. Temperature computation and register decoding are handled elsewhere; this block takes the configuration fields as plain inputs.

Top module: `alert_pin_sense`

## Requirements
- R1: A tick occurs once every TICK_DIV clock cycles. With sensing enabled, a sense window opens every `period_i` ticks, i.e. every `period_i`*TICK_DIV cycles, and stays open for `assert_time_i`*TICK_DIV cycles.
- R2: An `assert_time_i` value of 0 or 1 is reserved and is treated as 2, giving a window of 2*TICK_DIV cycles.
- R3: While `out_en_i` is 0, `drive_o` is 0 on both pins whatever `hot_req_i` is. `drv_valid_o` is cleared on the clock after `out_en_i` falls.
- R4: `drive_o[i]` is 1 (pin pulled low) when the pin's hot request is valid, `out_en_i` is 1 and no sense window is open. Both pins are released together for the whole window.
- R5: With `sense_en_i` at 1, `ext_hot_o[i]` takes the synchronized pin level at the last tick of each window: 1 if the pin was low, 0 if it was high. With `sense_en_i` at 0, no window opens, the drive is never released and the flags are 0 from the next clock.
- R6: Detection of external assertion works the same with `out_en_i` at 0.
- R7: `smi_o` is a pulse of exactly one cycle on each rise of the OR of the two flags, and only while `smi_en_i` and `sense_en_i` are both 1. It never fires while `smi_en_i` is 0.
- R8: A change of `period_i` or `assert_time_i` restarts the prescaler and the period counter. A full-length window then opens on the next clock.
- R9: During reset, `drive_o`, `drv_valid_o`, `ext_hot_o` and `smi_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sense_en_i | input | 1 | Enables periodic sensing of external assertion |
| out_en_i | input | 1 | Enables driving the pins from hot requests |
| smi_en_i | input | 1 | Enables the interrupt event on external assertion |
| period_i | input | 10 | Sense period in ticks |
| assert_time_i | input | 3 | Sense window length in ticks (0 and 1 act as 2) |
| hot_req_i | input | 2 | Internal hot request per pin |
| pin_lvl_i | input | 2 | Sampled pad level per pin (0 = low, asserted) |
| drive_o | output | 2 | Pull-down enable per pin |
| drv_valid_o | output | 2 | Registered internally-driven-valid status per pin |
| ext_hot_o | output | 2 | External-assert flag per pin |
| smi_o | output | 1 | One-cycle interrupt event |

## Verification
The assertions assume that `period_i` is larger than the effective assertion time, so that every window ends before the next period starts. They also assume that the pads follow wired-AND behaviour, with the pin low whenever this block or the outside agent pulls it. The bench models each pad as the NOR of `drive_o` and an external pull. It uses periods of 12 ticks against windows of at most 5 ticks. It changes configuration only at a window end, or in the same cycle sensing is switched on, so that every window it measures is complete.

// File: rtl/aps_pkg.sv
package aps_pkg;
  localparam int unsigned APS_NPIN = 2;
  localparam int unsigned APS_PER_W = 10;
  localparam int unsigned APS_ASR_W = 3;
  localparam int unsigned APS_ASR_MIN = 2;

  // reserved assertion times fall back to the minimum
  function automatic logic [APS_ASR_W-1:0] clamp_asr(input logic [APS_ASR_W-1:0] v);
    return (v < APS_ASR_W'(APS_ASR_MIN)) ? APS_ASR_W'(APS_ASR_MIN) : v;
  endfunction
endpackage

// File: rtl/aps_tick.sv
module aps_tick #(
  parameter int unsigned TICK_DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || tick_o)    cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/aps_sched.sv
module aps_sched
  import aps_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 restart_i,
  input  logic                 sense_en_i,
  input  logic [APS_PER_W-1:0] period_i,
  input  logic [APS_ASR_W-1:0] asr_i,
  output logic                 win_o,
  output logic                 sample_o
);
  logic [APS_PER_W-1:0] pcnt_q;
  logic [APS_PER_W:0]   pnext;
  logic [APS_PER_W-1:0] asr_ext;

  assign pnext   = {1'b0, pcnt_q} + 1'b1;
  assign asr_ext = APS_PER_W'(clamp_asr(asr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt_q <= '0;
    else if (restart_i) pcnt_q <= '0;
    else if (tick_i) begin
      if (pnext >= {1'b0, period_i}) pcnt_q <= '0;
      else                           pcnt_q <= pnext[APS_PER_W-1:0];
    end
  end

  // window occupies the first asr ticks of every period
  assign win_o    = sense_en_i && (pcnt_q < asr_ext);
  assign sample_o = win_o && tick_i && !restart_i && (pcnt_q == asr_ext - 1'b1);
endmodule

// File: rtl/aps_sync.sv
module aps_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/alert_pin_sense.sv
module alert_pin_sense
  import aps_pkg::*;
#(
  parameter int unsigned TICK_DIV = 100,
  parameter int unsigned DEF_PERIOD = 200,
  parameter int unsigned DEF_ASR = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sense_en_i,
  input  logic                 out_en_i,
  input  logic                 smi_en_i,
  input  logic [APS_PER_W-1:0] period_i,
  input  logic [APS_ASR_W-1:0] assert_time_i,
  input  logic [APS_NPIN-1:0]  hot_req_i,
  input  logic [APS_NPIN-1:0]  pin_lvl_i,
  output logic [APS_NPIN-1:0]  drive_o,
  output logic [APS_NPIN-1:0]  drv_valid_o,
  output logic [APS_NPIN-1:0]  ext_hot_o,
  output logic                 smi_o
);
  logic [APS_PER_W-1:0] per_q;
  logic [APS_ASR_W-1:0] asr_q;
  logic                 restart, tick, sense_win, sample;
  logic [APS_NPIN-1:0]  lvl_s, ext_q, drv_q;
  logic                 any_q;

  // config change restarts timing so a window is never cut short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= APS_PER_W'(DEF_PERIOD);
      asr_q <= APS_ASR_W'(DEF_ASR);
    end else begin
      per_q <= period_i;
      asr_q <= assert_time_i;
    end
  end
  assign restart = (period_i != per_q) || (assert_time_i != asr_q);

  aps_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .tick_o   (tick)
  );

  aps_sched u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .restart_i (restart),
    .sense_en_i(sense_en_i),
    .period_i  (period_i),
    .asr_i     (assert_time_i),
    .win_o     (sense_win),
    .sample_o  (sample)
  );

  aps_sync #(.WIDTH(APS_NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_lvl_i),
    .q_o   (lvl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       drv_q <= '0;
    else if (out_en_i) drv_q <= hot_req_i;
    else               drv_q <= '0;
  end

  for (genvar p = 0; p < APS_NPIN; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ext_q[p] <= 1'b0;
      else if (!sense_en_i) ext_q[p] <= 1'b0;
      else if (sample)      ext_q[p] <= ~lvl_s[p];
    end
    assign drive_o[p] = drv_q[p] && out_en_i && !sense_win;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_q <= 1'b0;
    else         any_q <= |ext_q;
  end

  assign smi_o       = smi_en_i && sense_en_i && (|ext_q) && !any_q;
  assign drv_valid_o = drv_q;
  assign ext_hot_o   = ext_q;
endmodule

// File: rtl/alert_pin_sense_chk.sv
module alert_pin_sense_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sense_en_i,
  input logic       out_en_i,
  input logic       smi_en_i,
  input logic [1:0] drive_o,
  input logic [1:0] drv_valid_o,
  input logic [1:0] ext_hot_o,
  input logic       smi_o,
  input logic       sense_win
);
  // R3
  out_off_clears_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> (drv_valid_o == 2'b00));

  // R4
  drive_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o != 2'b00) |-> ((drive_o & ~drv_valid_o) == 2'b00) && !sense_win);

  // R5
  sense_off_clears_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sense_en_i |=> (ext_hot_o == 2'b00));

  // R5
  flags_move_after_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_en_i && $past(sense_en_i) && !$stable(ext_hot_o)) |-> $past(sense_win));

  // R7
  smi_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |=> !smi_o);

  // R7
  smi_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> (smi_en_i && sense_en_i && (ext_hot_o != 2'b00)));
endmodule

bind alert_pin_sense alert_pin_sense_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sense_en_i (sense_en_i),
  .out_en_i   (out_en_i),
  .smi_en_i   (smi_en_i),
  .drive_o    (drive_o),
  .drv_valid_o(drv_valid_o),
  .ext_hot_o  (ext_hot_o),
  .smi_o      (smi_o),
  .sense_win  (sense_win)
);

// File: tb/tb_alert_pin_sense.sv
module tb_alert_pin_sense;
  localparam int DIV = 4;
  localparam int PER = 12;

  typedef struct { int len; int gap; } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sense_en = 1'b0, out_en = 1'b1, smi_en = 1'b0;
  logic [9:0] period = 10'd200;
  logic [2:0] asr = 3'd2;
  logic [1:0] hot = 2'b00, pull = 2'b00;
  logic [1:0] pin_lvl, drive, drv_valid, ext_hot;
  logic       smi;

  int checks = 0, errors = 0;
  exp_t q[$];
  int cyc = 0, start_c = -1, last_start = -1, gap_m = -1;
  int smi_cnt = 0, smi_long = 0, pin_mis = 0;
  logic prev_d = 1'b0, prev_smi = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // open-drain pads: low when either side pulls
  assign pin_lvl = ~(drive | pull);

  alert_pin_sense #(.TICK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sense_en_i(sense_en), .out_en_i(out_en),
    .smi_en_i(smi_en), .period_i(period), .assert_time_i(asr),
    .hot_req_i(hot), .pin_lvl_i(pin_lvl), .drive_o(drive),
    .drv_valid_o(drv_valid), .ext_hot_o(ext_hot), .smi_o(smi)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int len, input int gap);
    exp_t e;
    e.len = len;
    e.gap = gap;
    q.push_back(e);
  endtask

  task automatic wait_end();
    @(posedge drive[0]);
    @(negedge clk);
  endtask

  // monitor: measures release windows on pin 0 and compares to the queue
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_d && !drive[0]) begin
        start_c = cyc;
        gap_m = (last_start < 0) ? -1 : cyc - last_start;
        last_start = cyc;
      end
      if (!prev_d && drive[0] && start_c >= 0 && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(cyc - start_c == e.len, "R1 window length", cyc - start_c, e.len);
        if (e.gap >= 0) check(gap_m == e.gap, "R1 window spacing", gap_m, e.gap);
      end
      if (hot == 2'b11 && drive[0] != drive[1]) pin_mis++;
      if (smi) begin
        smi_cnt++;
        if (prev_smi) smi_long++;
      end
      prev_d = drive[0];
      prev_smi = smi;
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rel;
    repeat (3) @(negedge clk);
    // R9
    check(drive == 2'b00, "R9 drive in reset", drive, 0);
    check(drv_valid == 2'b00, "R9 valid in reset", drv_valid, 0);
    check(ext_hot == 2'b00 && smi == 1'b0, "R9 flags in reset", ext_hot, 0);
    rst_n = 1'b1;
    hot = 2'b11;
    repeat (2) @(negedge clk);
    check(drive == 2'b11, "R4 drive follows hot", drive, 3);
    // R5: no release without sensing
    rel = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (drive != 2'b11) rel++;
    end
    check(rel == 0, "R5 no window when sense off", rel, 0);

    // R1/R4/R8: enable sensing together with config change
    push(3*DIV, -1); push(3*DIV, PER*DIV); push(3*DIV, PER*DIV);
    sense_en = 1'b1; period = 10'(PER); asr = 3'd3;
    wait (q.size() == 0);
    check(pin_mis == 0, "R4 both pins released together", pin_mis, 0);

    // R8: restart at window end with a new assert time
    push(5*DIV, -1); push(5*DIV, PER*DIV);
    asr = 3'd5;
    wait (q.size() == 0);

    // R2: reserved values clamp to 2
    push(2*DIV, -1); push(2*DIV, PER*DIV);
    asr = 3'd0;
    wait (q.size() == 0);
    push(2*DIV, -1);
    asr = 3'd1;
    wait (q.size() == 0);

    // R5/R7: external pull on pin 1
    smi_en = 1'b1; pull = 2'b10;
    wait_end();
    check(ext_hot == 2'b10, "R5 pin1 flag set", ext_hot, 2);
    repeat (5) @(negedge clk);
    check(smi_cnt == 1, "R7 one event", smi_cnt, 1);
    wait_end();
    repeat (5) @(negedge clk);
    check(smi_cnt == 1, "R7 no event while held", smi_cnt, 1);
    pull = 2'b00;
    wait_end();
    check(ext_hot == 2'b00, "R5 flag clears when pin high", ext_hot, 0);
    pull = 2'b11;
    wait_end();
    check(ext_hot == 2'b11, "R5 both flags", ext_hot, 3);
    repeat (5) @(negedge clk);
    check(smi_cnt == 2 && smi_long == 0, "R7 single-cycle pulse", smi_cnt, 2);

    // R7: interrupt disabled
    smi_en = 1'b0; pull = 2'b00;
    wait_end();
    pull = 2'b01;
    wait_end();
    repeat (5) @(negedge clk);
    check(ext_hot == 2'b01, "R5 pin0 flag", ext_hot, 1);
    check(smi_cnt == 2, "R7 no event when disabled", smi_cnt, 2);

    // R3/R6: outputs off, sensing continues
    out_en = 1'b0;
    @(negedge clk);
    check(drive == 2'b00, "R3 drive off", drive, 0);
    @(negedge clk);
    check(drv_valid == 2'b00, "R3 valid cleared", drv_valid, 0);
    pull = 2'b00;
    repeat (3*PER*DIV) @(negedge clk);
    check(ext_hot == 2'b00, "R6 clear with outputs off", ext_hot, 0);
    pull = 2'b11;
    repeat (3*PER*DIV) @(negedge clk);
    check(ext_hot == 2'b11, "R6 detect with outputs off", ext_hot, 3);
    check(drive == 2'b00, "R3 still not driven", drive, 0);

    // R5: sensing off clears flags
    sense_en = 1'b0;
    @(negedge clk);
    check(ext_hot == 2'b00, "R5 flags cleared", ext_hot, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule